// File: doc/BRIEF.md
# Serial Switch-Input Monitor with Change Interrupt

This block watches a bus of switch inputs (8 or 16 wide, already synchronised to the core clock) and reports their state to a host over a four-wire serial slave port. Pulling chip select low freezes a snapshot of the inputs into a status register. While the port is selected, the first rising serial clock edge copies that snapshot into a shift register. Each further rising edge moves the data one place toward the serial output, most significant bit first. Serial input is picked up on each falling serial clock edge and fills the shift register from its low end. This lets several monitors share clock and select and be chained output-to-input, so the host reads the whole chain as one long word.

A change interrupt compares the live inputs with the snapshot and pulls the interrupt line low while they differ. The interrupt clears on the next chip select fall, or by itself when the inputs go back to the snapshot. An enable input can release the line at any time. The serial output and the interrupt are modelled as an enable/data pair and as a drive-low flag, so an integrator can wire several interrupts together as a wired-AND.

The serial pins are sampled on the core clock. Each serial clock level must last at least two core clock cycles, and the serial clock must be low whenever chip select changes. An unused serial input must be tied to 0. Reset is synchronous and must last at least one core clock edge.

Top module: `gpi_monitor`

## Requirements
- R1: On the core clock edge that first sees chip select low, the status register takes the value of `inBus`. Input changes after that edge do not alter the data read out in the same access.
- R2: While selected, the first rising serial clock edge loads the shift register from the status register. From then on `sdoData` shows status bit WIDTH-1.
- R3: Each later rising serial clock edge shifts the register one place toward bit WIDTH-1, with the bit taken from `sdin` at the previous falling edge entering bit 0. Once a device's own bits are out, it therefore passes its `sdin` stream on, and an unused `sdin` tied to 0 yields zeros.
- R4: `sdoEn` is 1 exactly while `csN` is 0. Serial clock activity while `csN` is 1 does not enable the output or raise the interrupt.
- R5: One core clock after `inBus` differs from the status register, `intDrive` becomes 1 (line pulled low). One core clock after they match again, it returns to 0.
- R6: A chip select fall clears the interrupt: `intDrive` is 0 on the cycle after the capture edge, even if it was 1 before.
- R7: While `intEn` is 0, `intDrive` is 0. Raising `intEn` with a mismatch pending makes `intDrive` 1 at once.
- R8: With N devices chained (`sdoData` to the next `sdin`) and a shared select and clock, the host reads N×WIDTH bits from the last device. The last device's status comes first, then each earlier device's, each MSB first. Interrupts combined as a wired-AND go low when any one device sees a change.
- R9: Reset loads the status register from `inBus`, so no interrupt is pending after reset. It also clears the shift register to zero (the first bit seen before any load is 0) and leaves the serial output released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in (tie to 0 if unused) |
| sdoData | output | 1 | Serial data out value |
| sdoEn | output | 1 | Serial data out enable; 0 means high impedance |
| inBus | input | WIDTH | Synchronised switch inputs |
| intEn | input | 1 | Interrupt output enable |
| intDrive | output | 1 | 1 pulls the active-low interrupt line low; 0 releases it |

## Verification
The hardest case to reach is a snapshot that differs from the inputs at the moment the shift register is loaded. That is the only way to tell capture on the select fall apart from capture on the first clock rise. The bench changes every input between the select fall and the first serial clock rise, then expects the old values in the readout, and expects the interrupt to be raised afterwards. Chaining three instances drives the bits that pass through the later devices' sample flops. A change on one device at a time shows the wired-AND interrupt line following that single device.

// File: rtl/gpi_monitor_pkg.sv
package gpi_monitor_pkg;

  // Strobes from the serial control to the datapath, one core cycle wide.
  typedef struct packed {
    logic capture;  // chip select has just fallen: snapshot the inputs
    logic load;     // first rising serial clock in this access
    logic shift;    // later rising serial clock
    logic sample;   // falling serial clock while selected
  } gpiStrobe_t;

endpackage

// File: rtl/gpi_monitor_ctrl.sv
module gpi_monitor_ctrl
  import gpi_monitor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  output gpiStrobe_t strobe
);

  logic csPrev;
  logic sclkPrev;
  logic firstPending;

  logic selected;
  logic sclkRise;
  logic sclkFall;

  always_comb begin
    selected       = ~csN;
    sclkRise       = selected & sclk & ~sclkPrev;
    sclkFall       = selected & ~sclk & sclkPrev;
    strobe.capture = csPrev & ~csN;
    strobe.load    = sclkRise & firstPending;
    strobe.shift   = sclkRise & ~firstPending;
    strobe.sample  = sclkFall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev       <= 1'b1;
      sclkPrev     <= 1'b0;
      firstPending <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      if (strobe.capture) begin
        firstPending <= 1'b1;
      end else if (strobe.load) begin
        firstPending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gpi_monitor_dp.sv
module gpi_monitor_dp
  import gpi_monitor_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpiStrobe_t       strobe,
  input  logic [WIDTH-1:0] inBus,
  input  logic             sdin,
  output logic [WIDTH-1:0] statusReg,
  output logic [WIDTH-1:0] shiftReg,
  output logic             sampleBit,
  output logic             sdoData
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shiftNext;

  generate
    if (WIDTH > 1) begin : g_wide
      always_comb shiftNext = {shiftReg[MSB-1:0], sampleBit};
    end else begin : g_single
      always_comb shiftNext = sampleBit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= inBus;
      shiftReg  <= '0;
      sampleBit <= 1'b0;
    end else begin
      if (strobe.capture) statusReg <= inBus;
      if (strobe.sample)  sampleBit <= sdin;
      if (strobe.load) begin
        shiftReg <= statusReg;
      end else if (strobe.shift) begin
        shiftReg <= shiftNext;
      end
    end
  end

  assign sdoData = shiftReg[MSB];

endmodule

// File: rtl/gpi_monitor_irq.sv
module gpi_monitor_irq #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capture,
  input  logic [WIDTH-1:0] inBus,
  input  logic [WIDTH-1:0] statusReg,
  input  logic             intEn,
  output logic             intDrive
);

  logic mismatch;
  logic intReg;

  assign mismatch = |(inBus ^ statusReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intReg <= 1'b0;
    end else begin
      intReg <= capture ? 1'b0 : mismatch;
    end
  end

  assign intDrive = intEn & intReg;

endmodule

// File: rtl/gpi_monitor.sv
module gpi_monitor
  import gpi_monitor_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdin,
  output logic             sdoData,
  output logic             sdoEn,
  input  logic [WIDTH-1:0] inBus,
  input  logic             intEn,
  output logic             intDrive
);

  gpiStrobe_t       strobe;
  logic [WIDTH-1:0] statusReg;
  logic [WIDTH-1:0] shiftReg;
  logic             sampleBit;

  gpi_monitor_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .strobe (strobe)
  );

  gpi_monitor_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inBus     (inBus),
    .sdin      (sdin),
    .statusReg (statusReg),
    .shiftReg  (shiftReg),
    .sampleBit (sampleBit),
    .sdoData   (sdoData)
  );

  gpi_monitor_irq #(.WIDTH(WIDTH)) u_irq (
    .clk       (clk),
    .rstN      (rstN),
    .capture   (strobe.capture),
    .inBus     (inBus),
    .statusReg (statusReg),
    .intEn     (intEn),
    .intDrive  (intDrive)
  );

  assign sdoEn = ~csN;

endmodule

// File: rtl/gpi_monitor_chk.sv
module gpi_monitor_chk
  import gpi_monitor_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic [WIDTH-1:0] inBus,
  input logic             intDrive,
  input gpiStrobe_t       strobe,
  input logic [WIDTH-1:0] statusReg,
  input logic [WIDTH-1:0] shiftReg,
  input logic             sampleBit
);

  localparam int MSB = WIDTH - 1;

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> statusReg == $past(inBus));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> shiftReg == $past(statusReg));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> shiftReg == {$past(shiftReg[MSB-1:0]), $past(sampleBit)});

  assert_int_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    intDrive |-> $past(inBus != statusReg));

  assert_int_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> !intDrive);

endmodule

bind gpi_monitor gpi_monitor_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .inBus     (inBus),
  .intDrive  (intDrive),
  .strobe    (strobe),
  .statusReg (statusReg),
  .shiftReg  (shiftReg),
  .sampleBit (sampleBit)
);

// File: tb/gpi_monitor_tb.sv
module gpi_monitor_tb;

  localparam int W     = 16;
  localparam int NBITS = 3 * W + 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN = 1'b0;
  logic         csN  = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] inA, inB, inD;
  logic         enA = 1'b1, enB = 1'b1, enD = 1'b1;
  logic         sdoA, sdoB, sdoD;
  logic         oeA, oeB, oeD;
  logic         intA, intB, intD;
  logic         wiredLine;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  gpi_monitor #(.WIDTH(W)) u_first (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdin(1'b0),
    .sdoData(sdoA), .sdoEn(oeA), .inBus(inA), .intEn(enA), .intDrive(intA));

  gpi_monitor #(.WIDTH(W)) u_mid (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdin(sdoA),
    .sdoData(sdoB), .sdoEn(oeB), .inBus(inB), .intEn(enB), .intDrive(intB));

  gpi_monitor #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdin(sdoB),
    .sdoData(sdoD), .sdoEn(oeD), .inBus(inD), .intEn(enD), .intDrive(intD));

  // Wired-AND of the open-drain lines: 1 = released (pulled up)
  assign wiredLine = ~(intA | intB | intD);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic csDown();
    csN = 1'b0; tick(); tick();
  endtask

  task automatic csUp();
    csN = 1'b1; tick(); tick();
  endtask

  task automatic clockBits(input int n, output logic [NBITS-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; tick(); tick();
      got = {got[NBITS-2:0], sdoD};
      sclk = 1'b0; tick(); tick();
    end
  endtask

  task automatic syncAll();
    csDown(); csUp();
  endtask

  task automatic t_reset();
    check(intA == 0 && intB == 0 && intD == 0, "R9 no interrupt after reset",
          {intA, intB, intD}, 0);
    check(oeD == 0, "R4 released while deselected", oeD, 0);
    csDown();
    check(oeD == 1, "R4 driven while selected", oeD, 1);
    check(sdoD == 0, "R9 shift register cleared", sdoD, 0);
    csUp();
    check(oeD == 0, "R4 released after deselect", oeD, 0);
  endtask

  task automatic t_chainRead(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [W-1:0] d);
    logic [NBITS-1:0] got;
    inA = a; inB = b; inD = d;
    tick(); tick();
    syncAll();
    csDown();
    inA = ~a; inB = ~b; inD = ~d;   // change after snapshot, before first rise
    clockBits(NBITS, got);
    check(got[NBITS-1] == d[W-1], "R2 first bit is MSB of status", got[NBITS-1], d[W-1]);
    check(got[NBITS-1 -: W] == d, "R1 snapshot taken at select fall", got[NBITS-1 -: W], d);
    check(got == {d, b, a, 4'b0000}, "R8 chained readout order", got, {d, b, a, 4'b0000});
    check(got[3:0] == 4'b0000, "R3 tied-off serial input shifts zeros", got[3:0], 0);
    csUp();
    check(intA && intB && intD, "R5 interrupt after inputs left snapshot",
          {intA, intB, intD}, 3'b111);
    syncAll();
  endtask

  task automatic t_interrupt();
    syncAll();
    inB[3] = ~inB[3];
    check(intB == 0, "R5 no interrupt before clock edge", intB, 0);
    tick();
    check(intB == 1 && intA == 0 && intD == 0, "R5 one device flags change",
          {intA, intB, intD}, 3'b010);
    check(wiredLine == 0, "R8 wired-AND line low on one change", wiredLine, 0);
    inB[3] = ~inB[3];
    tick();
    check(intB == 0, "R5 self-clear on match", intB, 0);
    check(wiredLine == 1, "R8 wired-AND line released", wiredLine, 1);
  endtask

  task automatic t_csClear();
    syncAll();
    inD = inD ^ 16'h0101;
    tick();
    check(intD == 1, "R5 change raises interrupt", intD, 1);
    csN = 1'b0;
    tick();
    check(intD == 0, "R6 select fall clears interrupt", intD, 0);
    tick();
    check(intD == 0, "R6 stays clear after capture", intD, 0);
    csUp();
  endtask

  task automatic t_mask();
    syncAll();
    enD = 1'b0;
    inD[0] = ~inD[0];
    tick(); tick();
    check(intD == 0 && wiredLine == 1, "R7 masked interrupt released",
          {intD, wiredLine}, 2'b01);
    enD = 1'b1;
    #1;
    check(intD == 1, "R7 pending interrupt shows on enable", intD, 1);
    syncAll();
    check(intD == 0, "R6 cleared after access", intD, 0);
  endtask

  task automatic t_idleClocks();
    logic [NBITS-1:0] got;
    syncAll();
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; tick(); tick();
      sclk = 1'b0; tick(); tick();
    end
    check(oeD == 0 && wiredLine == 1, "R4 idle clocks have no effect",
          {oeD, wiredLine}, 2'b01);
    csDown();
    clockBits(NBITS, got);
    csUp();
    check(got == {inD, inB, inA, 4'b0000}, "R2 read after idle clocks",
          got, {inD, inB, inA, 4'b0000});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    inA = 16'h1234; inB = 16'h00FF; inD = 16'hA5C3;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_chainRead(16'hF00D, 16'h8001, 16'h5A3C);
    t_chainRead(16'h0000, 16'hFFFF, 16'hAAAA);
    t_chainRead(16'h7FFE, 16'h0001, 16'h8000);
    t_interrupt();
    t_csClear();
    t_mask();
    t_idleClocks();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule